// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system read and write a 262144 x 1 asynchronous static RAM. A client hands over one request at a time on a valid/ready handshake. Each request carries an 18-bit word address, a single write bit and a read/write flag. The sequencer then walks the RAM pins through a fixed series of clock-counted phases. For a write these are select, strobe and hold. For a read it is a single access window, at the end of which the RAM output is sampled and returned with a one-cycle valid pulse.

Every phase length is a parameter computed at elaboration. Each is the relevant nanosecond figure divided by the clock period, rounded up. The defaults describe the fast speed grade at a 4 ns clock; the slow grade is obtained by overriding the picosecond parameters. Whenever no request is pending, the RAM is deselected so it drops into standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `mem_sel_n` and `mem_wr_n` are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: `req_ready` is 1 only while no access is in progress; it is 0 in every cycle in which `mem_sel_n` is 0. A request offered while busy is taken only once `req_ready` returns, so every accepted request produces exactly one select window.
- R3: `mem_a` does not change in any cycle in which `mem_sel_n` is 0 and was 0 the cycle before.
- R4: `mem_wr_n` is 0 only in cycles in which `mem_sel_n` is also 0.
- R5: For a write (`req_wr`=1), `mem_sel_n` is low for at least SETUP_CYC cycles (minimum 1) before `mem_wr_n` falls. `mem_wr_n` then stays low for at least ceil(max(pulse, data setup)/period) cycles, which is 2 at the defaults. For one cycle after `mem_wr_n` rises, `mem_sel_n` stays low and `mem_a` and `mem_d` are unchanged.
- R6: A write stores `req_wdata` at `req_addr`. A later read of that address returns the bit last written; an address never written reads as whatever the RAM holds.
- R7: A read (`req_wr`=0) holds `mem_sel_n` low with `mem_wr_n` high for ceil(max(address access, select access, read cycle)/period) cycles, 3 at the defaults. It samples `mem_q` in the last of those cycles. `rd_data` is then presented with `rd_valid` high for exactly one cycle, the cycle after `mem_sel_n` rises.
- R8: When no request is pending, the RAM is deselected (`mem_sel_n`=1), and consecutive accesses are separated by at least one deselected cycle.
- R9: The select window of a write lasts at least ceil(write cycle/period) cycles, 3 at the defaults; at the defaults it is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle pulse with read result |
| rd_data | output | 1 | Read result |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_a | output | 18 | RAM address |
| mem_d | output | 1 | RAM write data |
| mem_q | input | 1 | RAM read data |

## Verification
The read-result pulse and the acceptance of the next request can land in the same cycle: a finished read returns to idle, and `req_ready` is high in exactly the cycle that carries `rd_valid`. The bench provokes this by keeping `req_valid` asserted back to back, including a write followed at once by a read of the same address. It judges the overlap two ways. First, the returned bit must match the bench's shadow store. Second, the new select window must open only after a deselected cycle, with the address held for its whole length. The RAM model returns the inverted bit until 11 ns after the last pin change, so any read window shorter than the parameterised access time shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WSTROBE = 3'd2,
    PH_WHOLD   = 3'd3,
    PH_READ    = 3'd4
  } phase_e;

  // cycles needed to cover a time in picoseconds, rounded up
  function automatic int ps_to_cyc(int t_ps, int per_ps);
    return (t_ps + per_ps - 1) / per_ps;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_wdata
);

  logic [ADDR_W-1:0] addr_q;
  logic              wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= 1'b0;
    end else if (capture) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  assign out_addr  = addr_q;
  assign out_wdata = wdata_q;

endmodule

// File: rtl/sram_phase_fsm.sv
`timescale 1ns/1ps
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  output logic             req_ready,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  input  logic             tmr_zero,
  input  logic             mem_q,
  output logic             mem_sel_n,
  output logic             mem_wr_n,
  output logic             rd_valid,
  output logic             rd_data
);

  phase_e st_q, st_d;
  logic   sample;
  logic   sel_n_q, wr_n_q, rdv_q, rdd_q;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    sample   = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (req_valid) begin
          capture  = 1'b1;
          tmr_load = 1'b1;
          if (req_wr) begin
            st_d    = PH_WSETUP;
            tmr_val = CNT_W'(SETUP_CYC - 1);
          end else begin
            st_d    = PH_READ;
            tmr_val = CNT_W'(ACCESS_CYC - 1);
          end
        end
      end
      PH_WSETUP: begin
        if (tmr_zero) begin
          st_d     = PH_WSTROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(STROBE_CYC - 1);
        end
      end
      PH_WSTROBE: begin
        if (tmr_zero) begin
          st_d     = PH_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      PH_WHOLD: begin
        if (tmr_zero) st_d = PH_IDLE;
      end
      PH_READ: begin
        if (tmr_zero) begin
          st_d   = PH_IDLE;
          sample = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      sel_n_q <= 1'b1;
      wr_n_q  <= 1'b1;
      rdv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_n_q <= (st_d == PH_IDLE);
      wr_n_q  <= (st_d != PH_WSTROBE);
      rdv_q   <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdd_q <= 1'b0;
    else if (sample) rdd_q <= mem_q;
  end

  assign req_ready = (st_q == PH_IDLE);
  assign mem_sel_n = sel_n_q;
  assign mem_wr_n  = wr_n_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !mem_sel_n); // R4
  AST_SEL_HELD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> !mem_sel_n); // R5
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_sel_n && $past(!mem_sel_n && mem_wr_n))); // R7

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_PS    = 4000,
  parameter int T_AS_PS   = 0,
  parameter int T_AW_PS   = 9000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 8000,
  parameter int T_WC_PS   = 12000,
  parameter int T_AA_PS   = 12000,
  parameter int T_ACE_PS  = 12000,
  parameter int T_RC_PS   = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              mem_sel_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_a,
  output logic              mem_d,
  input  logic              mem_q
);

  localparam int SETUP_CYC  = imax(1, ps_to_cyc(T_AS_PS, CLK_PS));
  localparam int AW_CYC     = ps_to_cyc(T_AW_PS, CLK_PS);
  localparam int STROBE_CYC = imax(imax(1, ps_to_cyc(T_PWE_PS, CLK_PS)),
                                   imax(ps_to_cyc(T_SD_PS, CLK_PS),
                                        AW_CYC - SETUP_CYC));
  localparam int WC_CYC     = ps_to_cyc(T_WC_PS, CLK_PS);
  localparam int HOLD_CYC   = imax(1, WC_CYC - SETUP_CYC - STROBE_CYC);
  localparam int ACCESS_CYC = imax(1, imax(ps_to_cyc(T_AA_PS, CLK_PS),
                                   imax(ps_to_cyc(T_ACE_PS, CLK_PS),
                                        ps_to_cyc(T_RC_PS, CLK_PS))));
  localparam int MAX_CYC    = imax(imax(SETUP_CYC, STROBE_CYC),
                                   imax(HOLD_CYC, ACCESS_CYC));
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_phase_fsm #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_wr(req_wr), .req_ready(req_ready),
    .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tmr_zero(tmr_zero), .mem_q(mem_q),
    .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_req_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .in_addr(req_addr), .in_wdata(req_wdata),
    .out_addr(mem_a), .out_wdata(mem_d)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_a)); // R3
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_d)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> !req_ready); // R2
  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

endmodule

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_wr, req_wdata;
  logic [AW-1:0] req_addr;
  logic          rd_valid, rd_data;
  logic          mem_sel_n, mem_wr_n, mem_d;
  logic [AW-1:0] mem_a;
  logic          mem_q;

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int windows = 0;
  bit done = 1'b0;

  bit ram[int];
  bit shadow[int];
  bit exp_q[$];

  always #2 clk = ~clk;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_sel_n(mem_sel_n),
    .mem_wr_n(mem_wr_n), .mem_a(mem_a), .mem_d(mem_d), .mem_q(mem_q)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ram_rd(int a);
    return ram.exists(a) ? ram[a] : 1'b0;
  endfunction

  function automatic bit shadow_rd(int a);
    return shadow.exists(a) ? shadow[a] : 1'b0;
  endfunction

  // RAM model: output valid only 11 ns after the last pin change
  realtime t_chg = 0.0;
  always @(mem_a or mem_sel_n or mem_wr_n) t_chg = $realtime;
  initial mem_q = 1'b0;
  always begin
    #0.5;
    if (!mem_sel_n && mem_wr_n && ($realtime - t_chg) >= 11.0)
      mem_q = ram_rd(int'(mem_a));
    else
      mem_q = ~ram_rd(int'(mem_a));
  end

  // pin monitor, sampled away from the active edge
  logic          p_sel = 1'b1, p_wr = 1'b1, p_rdv = 1'b0;
  logic [AW-1:0] p_a = '0;
  logic          p_d = 1'b0;
  int sel_cnt = 0, wr_cnt = 0;
  bit saw_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_sel_n && !p_sel)
        chk(mem_a == p_a, "R3 addr held", int'(mem_a), int'(p_a));
      if (!mem_wr_n)
        chk(!mem_sel_n, "R4 strobe without select", int'(mem_sel_n), 0);
      if (!mem_sel_n)
        chk(!req_ready, "R2 ready while busy", int'(req_ready), 0);
      if (!mem_sel_n && p_sel) begin
        sel_cnt = 1; saw_wr = 1'b0; windows++;
      end else if (!mem_sel_n) sel_cnt++;
      if (!mem_wr_n && p_wr) begin
        chk(sel_cnt - 1 >= 1, "R5 select before strobe", sel_cnt - 1, 1);
        wr_cnt = 1; saw_wr = 1'b1;
      end else if (!mem_wr_n) wr_cnt++;
      if (mem_wr_n && !p_wr) begin
        chk(wr_cnt >= 2, "R5 strobe width", wr_cnt, 2);
        chk(!mem_sel_n && mem_a == p_a && mem_d == p_d, "R5 hold after strobe",
            int'(mem_sel_n), 0);
        ram[int'(p_a)] = p_d;
      end
      if (mem_sel_n && !p_sel) begin
        if (saw_wr) chk(sel_cnt >= 3, "R9 write cycle length", sel_cnt, 3);
        else        chk(sel_cnt == 3, "R7 read window length", sel_cnt, 3);
      end
      if (rd_valid) begin
        bit e;
        chk(!p_rdv, "R7 rd_valid single pulse", int'(p_rdv), 0);
        chk(mem_sel_n, "R7 result after deselect", int'(mem_sel_n), 1);
        chk(exp_q.size() > 0, "R7 unexpected result", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 read data", int'(rd_data), int'(e));
        end
      end
    end
    p_sel = mem_sel_n; p_wr = mem_wr_n; p_a = mem_a; p_d = mem_d; p_rdv = rd_valid;
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(bit wr, int a, bit d);
    req_valid = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    issued++;
    if (wr) shadow[a] = d;
    else    exp_q.push_back(shadow_rd(a));
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_sel_n && mem_wr_n && req_ready && !rd_valid, "R1 reset outputs",
        int'({mem_sel_n, mem_wr_n, req_ready, rd_valid}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_sel_n && mem_wr_n && req_ready && !rd_valid, "R1 first idle cycle",
        int'({mem_sel_n, mem_wr_n, req_ready, rd_valid}), 4'b1110);

    // directed corners
    issue(1'b1, 0, 1'b0);
    issue(1'b1, 32'h3FFFF, 1'b1);
    issue(1'b0, 0, 1'b0);
    issue(1'b0, 32'h3FFFF, 1'b0);
    issue(1'b0, 32'h155AA, 1'b0);        // never written
    issue(1'b1, 77, 1'b1);
    issue(1'b0, 77, 1'b0);               // back-to-back read of fresh write
    issue(1'b1, 77, 1'b0);
    issue(1'b0, 77, 1'b0);               // overwrite visible
    idle(6);
    chk(mem_sel_n, "R8 deselected when idle", int'(mem_sel_n), 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit wr = ($urandom_range(0, 1) == 1);
      int a  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 32'h3FFFF))
                                           : int'($urandom_range(0, 15));
      issue(wr, a, 1'(($urandom_range(0, 1))));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end

    idle(12);
    for (int k = 0; k < 8; k++) begin
      chk(mem_sel_n && mem_wr_n, "R8 idle deselect", int'(mem_sel_n), 1);
      @(negedge clk);
    end
    chk(windows == issued, "R2 one window per request", windows, issued);
    chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

endmodule